// File: doc/BRIEF.md
# Tri-Rate Serial Video Test Pattern Generator

This block produces a parallel test stream for a tri-rate serial digital video transmitter. One set of horizontal and vertical counters covers three signal standards: standard definition (a 270 Mb/s serial stream, interlaced, one 10-bit sample per word), HD (1080 interlaced) and 3G (1080 progressive). In HD and 3G each word carries a luma/chroma pair. Each standard's line length, active width, line count, vertical blanking and second-field start are parameters. The defaults are the broadcast rasters. Every line is framed by end-of-active-video and start-of-active-video timing reference sequences, and the blanking areas are filled with the black level.

The picture area shows one of three patterns. Two are eight-bar colour bars, at full or reduced amplitude. The third is a pathological checkfield: an equaliser-stress half followed by a PLL-stress half. The standard, pattern and amplitude selects are sampled only at a frame boundary, so a stream never changes format in mid-frame. Serialisation, scrambling, CRC and line-number insertion are left to the transmitter downstream.

Top module: `sdi_pattern_gen`

## Requirements
- R1: While reset is asserted, and until the first word is produced, `vid_valid` is 0, `vid_data` is 0 and `std_code` is 00. The first valid word after reset is word 0 of line 0 of a frame.
- R2: `std_code` reports 00 for SD, 01 for HD and 11 for 3G. A select value of 10 is treated as HD and reported as 01. `std_code` is aligned with the data word it accompanies.
- R3: Every line starts with four timing words at word positions 0..3: 0x3FF, 0x000, 0x000, XYZ, with H=1. The same four-word sequence with H=0 occupies the four words just before the active area. In HD and 3G both 10-bit halves carry the same timing word. In SD the word is on bits 9:0 and bits 19:10 are zero.
- R4: The XYZ word has the following bits: bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H. Bits 5..2 are V^H, F^H, F^V and F^V^H, in that order. Bits 1:0 are 0.
- R5: SD and HD frames have two fields, and F=1 from the second-field start line onward. 3G frames are progressive and F is always 0. V=1 on the first VBLANK lines of each field.
- R6: Blanking words carry luma 0x040 and chroma 0x200. In SD the chroma and luma alternate: chroma on even word positions, luma on odd ones.
- R7: Colour bars are eight equal-width bars, in order from the left: white, yellow, cyan, green, magenta, red, blue, black. At full amplitude (amplitude select 1), white luma is 940 and yellow luma is 877. At reduced amplitude (select 0), white luma is 721 and yellow luma is 674. Black luma is 64, and the chroma of white and black is 512 at both amplitudes.
- R8: In HD and 3G, bits 19:10 carry luma and bits 9:0 carry chroma, with Cb on even active words and Cr on odd ones. In SD the active samples repeat the order Cb, Y, Cr, Y.
- R9: A pattern select of 1 gives the checkfield whatever the amplitude select is. The first half of the frame's active lines carry chroma 0x300 and luma 0x198. The remaining active lines carry chroma 0x200 and luma 0x110.
- R10: A change on any select input takes effect only at word 0 of line 0 of the next frame. Data and `std_code` of the current frame are unaffected.
- R11: In HD and 3G, one valid word is produced per clock. In SD, one valid word is produced every SD_CE_DIV clocks.
- R12: Outside the timing words, no 10-bit channel ever carries a value in 0x000..0x003 or 0x3FC..0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| std_sel | input | 2 | Requested standard: 00 SD, 01 HD, 11 3G, 10 as HD |
| chk_sel | input | 1 | 1 selects the pathological checkfield |
| amp_sel | input | 1 | Bar amplitude: 1 full, 0 reduced |
| vid_data | output | 20 | Parallel video word |
| vid_valid | output | 1 | Strobe marking a valid `vid_data` word |
| std_code | output | 2 | Standard of the word on `vid_data` |

## Verification
The bench builds the generator with reduced rasters. SD has a 48-word line, 32 active words, 10 lines, 2 blanking lines per field and the second field at line 5. HD has a 40-word line, 24 active words, 8 lines and the second field at line 4. 3G has a 40-word line, 24 active words and 6 progressive lines. SD_CE_DIV is 2. With these values a whole frame of each standard completes in a few hundred words. The bench can therefore follow four back-to-back frames and check field transitions, both checkfield halves, bar boundaries and every select change at its frame edge. A full 1080-line raster would put these cases out of reach.

// File: rtl/sdi_tpg_pkg.sv
package sdi_tpg_pkg;

  typedef enum logic [1:0] {
    STD_SD = 2'b00,
    STD_HD = 2'b01,
    STD_3G = 2'b11
  } std_e;

  typedef struct packed {
    std_e std;
    logic chk;
    logic full;
  } tpg_cfg_t;

  typedef struct packed {
    logic [9:0] y;
    logic [9:0] cb;
    logic [9:0] cr;
  } ycc_t;

  // position flags passed from the raster counters to the datapath
  typedef struct packed {
    logic       eav;
    logic       sav;
    logic       act;
    logic       first_act;
    logic       last_sav;
    logic       f;
    logic       v;
    logic       first_half;
    logic       h_odd;
    logic [1:0] trs_idx;
    logic [1:0] aw_ph;
  } tpg_pos_t;

  localparam logic [9:0] BLK_Y = 10'h040;
  localparam logic [9:0] BLK_C = 10'h200;

  function automatic std_e std_decode(input logic [1:0] s);
    case (s)
      2'b00:   return STD_SD;
      2'b11:   return STD_3G;
      default: return STD_HD;
    endcase
  endfunction

  function automatic logic [9:0] xyz_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic ycc_t bar_color(input logic [2:0] idx, input logic full);
    ycc_t c;
    case (idx)
      3'd0: c = full ? {10'd940, 10'd512, 10'd512} : {10'd721, 10'd512, 10'd512};
      3'd1: c = full ? {10'd877, 10'd64,  10'd553} : {10'd674, 10'd176, 10'd543};
      3'd2: c = full ? {10'd753, 10'd615, 10'd64 } : {10'd581, 10'd589, 10'd176};
      3'd3: c = full ? {10'd690, 10'd167, 10'd105} : {10'd534, 10'd253, 10'd207};
      3'd4: c = full ? {10'd314, 10'd857, 10'd919} : {10'd251, 10'd771, 10'd817};
      3'd5: c = full ? {10'd251, 10'd409, 10'd960} : {10'd204, 10'd435, 10'd848};
      3'd6: c = full ? {10'd127, 10'd960, 10'd471} : {10'd111, 10'd848, 10'd481};
      default: c = {10'd64, 10'd512, 10'd512};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdi_tpg_timing.sv
module sdi_tpg_timing
  import sdi_tpg_pkg::*;
#(
  parameter int SD_TOTAL   = 1716,
  parameter int SD_ACTIVE  = 1440,
  parameter int SD_LINES   = 525,
  parameter int SD_VBLANK  = 19,
  parameter int SD_FIELD2  = 263,
  parameter int HD_TOTAL   = 2200,
  parameter int HD_ACTIVE  = 1920,
  parameter int HD_LINES   = 1125,
  parameter int HD_VBLANK  = 20,
  parameter int HD_FIELD2  = 563,
  parameter int G3_TOTAL   = 2200,
  parameter int G3_ACTIVE  = 1920,
  parameter int G3_LINES   = 1125,
  parameter int G3_VBLANK  = 41,
  parameter int SD_CE_DIV  = 5,
  parameter int HW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    std_sel,
  input  logic          chk_sel,
  input  logic          amp_sel,
  output logic          ce,
  output logic          run,
  output tpg_cfg_t      cfg,
  output tpg_pos_t      pos,
  output logic [HW-1:0] barw
);

  localparam int LW = $clog2(max3(SD_LINES, HD_LINES, G3_LINES) + 1);
  localparam int DW = (SD_CE_DIV > 1) ? $clog2(SD_CE_DIV) : 1;

  logic [HW-1:0] h_q, h_d;
  logic [LW-1:0] ln_q, ln_d;
  logic [LW:0]   vact_q, vact_d;
  logic [DW-1:0] div_q, div_d;
  logic          idle_q, idle_d;
  tpg_cfg_t      cfg_q, cfg_d;

  logic [HW-1:0] tot, act, hs, sav_off, aw;
  logic [LW-1:0] lines, vb, f2, lrel;
  logic [LW:0]   act_lines;
  logic          ce_div, h_end, frame_end, fld2, vbl;

  // per-standard raster limits
  always_comb begin
    case (cfg_q.std)
      STD_SD: begin
        tot = HW'(SD_TOTAL); act = HW'(SD_ACTIVE);
        lines = LW'(SD_LINES); vb = LW'(SD_VBLANK); f2 = LW'(SD_FIELD2);
      end
      STD_3G: begin
        tot = HW'(G3_TOTAL); act = HW'(G3_ACTIVE);
        lines = LW'(G3_LINES); vb = LW'(G3_VBLANK); f2 = '0;
      end
      default: begin
        tot = HW'(HD_TOTAL); act = HW'(HD_ACTIVE);
        lines = LW'(HD_LINES); vb = LW'(HD_VBLANK); f2 = LW'(HD_FIELD2);
      end
    endcase
  end

  // word clock enable
  assign ce_div = (div_q == DW'(SD_CE_DIV - 1));
  assign div_d  = ce_div ? '0 : div_q + DW'(1);
  assign ce     = (cfg_q.std == STD_SD) ? ce_div : 1'b1;

  // position decode
  assign hs        = tot - act;
  assign h_end     = (h_q == tot - HW'(1));
  assign frame_end = h_end && (ln_q == lines - LW'(1));
  assign fld2      = (f2 != '0) && (ln_q >= f2);
  assign lrel      = fld2 ? ln_q - f2 : ln_q;
  assign vbl       = (lrel < vb);
  assign sav_off   = h_q - (hs - HW'(4));
  assign aw        = h_q - hs;
  assign act_lines = {1'b0, lines} - ((f2 != '0) ? {vb, 1'b0} : {1'b0, vb});
  assign barw      = act >> 3;

  always_comb begin
    pos.eav        = (h_q < HW'(4));
    pos.sav        = (h_q >= hs - HW'(4)) && (h_q < hs);
    pos.act        = (h_q >= hs);
    pos.first_act  = (h_q == hs);
    pos.last_sav   = (h_q == hs - HW'(1));
    pos.f          = fld2;
    pos.v          = vbl;
    pos.first_half = (vact_q < (act_lines >> 1));
    pos.h_odd      = h_q[0];
    pos.trs_idx    = (h_q < HW'(4)) ? h_q[1:0] : sav_off[1:0];
    pos.aw_ph      = aw[1:0];
  end

  // next state
  always_comb begin
    h_d    = h_q;
    ln_d   = ln_q;
    vact_d = vact_q;
    idle_d = idle_q;
    cfg_d  = cfg_q;
    if (ce) begin
      if (idle_q || frame_end) begin
        h_d        = '0;
        ln_d       = '0;
        vact_d     = '0;
        idle_d     = 1'b0;
        cfg_d.std  = std_decode(std_sel);
        cfg_d.chk  = chk_sel;
        cfg_d.full = amp_sel;
      end else if (h_end) begin
        h_d  = '0;
        ln_d = ln_q + LW'(1);
        if (!vbl) vact_d = vact_q + (LW+1)'(1);
      end else begin
        h_d = h_q + HW'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      ln_q   <= '0;
      vact_q <= '0;
      div_q  <= '0;
      idle_q <= 1'b1;
      cfg_q  <= '{std: STD_SD, chk: 1'b0, full: 1'b0};
    end else begin
      div_q  <= div_d;
      h_q    <= h_d;
      ln_q   <= ln_d;
      vact_q <= vact_d;
      idle_q <= idle_d;
      cfg_q  <= cfg_d;
    end
  end

  assign run = !idle_q;
  assign cfg = cfg_q;

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (h_q != '0 || ln_q != '0)) |-> $stable(cfg_q));

  assert_std_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.std != 2'b10);

  assert_h_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q < tot) && (ln_q < lines));

endmodule

// File: rtl/sdi_tpg_pattern.sv
module sdi_tpg_pattern
  import sdi_tpg_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          run,
  input  tpg_cfg_t      cfg,
  input  tpg_pos_t      pos,
  input  logic [HW-1:0] barw,
  output ycc_t          px
);

  logic [HW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (ce && run) begin
      if (pos.last_sav) begin
        cnt_d = '0;
        idx_d = '0;
      end else if (pos.act) begin
        if (cnt_q == barw - HW'(1)) begin
          cnt_d = '0;
          idx_d = idx_q + 3'd1;
        end else begin
          cnt_d = cnt_q + HW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    if (cfg.chk) begin
      px = pos.first_half ? {10'h198, 10'h300, 10'h300} : {10'h110, 10'h200, 10'h200};
    end else begin
      px = bar_color(idx_q, cfg.full);
    end
  end

  assert_bar_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pos.first_act) |-> (idx_q == 3'd0 && cnt_q == '0));

endmodule

// File: rtl/sdi_tpg_format.sv
module sdi_tpg_format
  import sdi_tpg_pkg::*;
#(
  parameter int SD_CE_DIV = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce,
  input  logic        run,
  input  tpg_cfg_t    cfg,
  input  tpg_pos_t    pos,
  input  ycc_t        px,
  output logic [19:0] dout,
  output logic        dval,
  output logic [1:0]  std_out
);

  logic [19:0] w;
  logic [9:0]  t, s;
  logic        trs, sd;
  logic [19:0] dout_q;
  logic        dval_q, trs_q;
  std_e        std_q;

  assign sd = (cfg.std == STD_SD);

  always_comb begin
    t   = 10'h000;
    s   = 10'h000;
    trs = 1'b0;
    if (pos.eav || pos.sav) begin
      trs = 1'b1;
      case (pos.trs_idx)
        2'd0:    t = 10'h3FF;
        2'd3:    t = xyz_word(pos.f, pos.v, pos.eav);
        default: t = 10'h000;
      endcase
      w = sd ? {10'h000, t} : {t, t};
    end else if (pos.act && !pos.v) begin
      case (pos.aw_ph)
        2'd0:    s = px.cb;
        2'd2:    s = px.cr;
        default: s = px.y;
      endcase
      w = sd ? {10'h000, s} : {px.y, pos.aw_ph[0] ? px.cr : px.cb};
    end else begin
      w = sd ? {10'h000, pos.h_odd ? BLK_Y : BLK_C} : {BLK_Y, BLK_C};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dval_q <= 1'b0;
      trs_q  <= 1'b0;
      std_q  <= STD_SD;
    end else begin
      dval_q <= ce && run;
      if (ce && run) begin
        dout_q <= w;
        trs_q  <= trs;
        std_q  <= cfg.std;
      end
    end
  end

  assign dout    = dout_q;
  assign dval    = dval_q;
  assign std_out = std_q;

  assert_no_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dval_q && !trs_q) |->
      ((dout_q[9:0] > 10'h003) && (dout_q[9:0] < 10'h3FC) &&
       ((std_q == STD_SD) ? (dout_q[19:10] == 10'h000)
                          : ((dout_q[19:10] > 10'h003) && (dout_q[19:10] < 10'h3FC)))));

  generate
    if (SD_CE_DIV > 1) begin : g_sd_rate
      assert_sd_rate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dval_q && std_q == STD_SD) |=> (!dval_q || std_q != STD_SD));
    end
  endgenerate

endmodule

// File: rtl/sdi_pattern_gen.sv
module sdi_pattern_gen
  import sdi_tpg_pkg::*;
#(
  parameter int SD_TOTAL   = 1716,
  parameter int SD_ACTIVE  = 1440,
  parameter int SD_LINES   = 525,
  parameter int SD_VBLANK  = 19,
  parameter int SD_FIELD2  = 263,
  parameter int HD_TOTAL   = 2200,
  parameter int HD_ACTIVE  = 1920,
  parameter int HD_LINES   = 1125,
  parameter int HD_VBLANK  = 20,
  parameter int HD_FIELD2  = 563,
  parameter int G3_TOTAL   = 2200,
  parameter int G3_ACTIVE  = 1920,
  parameter int G3_LINES   = 1125,
  parameter int G3_VBLANK  = 41,
  parameter int SD_CE_DIV  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  std_sel,
  input  logic        chk_sel,
  input  logic        amp_sel,
  output logic [19:0] vid_data,
  output logic        vid_valid,
  output logic [1:0]  std_code
);

  localparam int HW = $clog2(max3(SD_TOTAL, HD_TOTAL, G3_TOTAL) + 1);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          ce, run;
  tpg_cfg_t      cfg;
  tpg_pos_t      pos;
  logic [HW-1:0] barw;
  ycc_t          px;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sdi_tpg_timing #(
    .SD_TOTAL(SD_TOTAL), .SD_ACTIVE(SD_ACTIVE), .SD_LINES(SD_LINES),
    .SD_VBLANK(SD_VBLANK), .SD_FIELD2(SD_FIELD2),
    .HD_TOTAL(HD_TOTAL), .HD_ACTIVE(HD_ACTIVE), .HD_LINES(HD_LINES),
    .HD_VBLANK(HD_VBLANK), .HD_FIELD2(HD_FIELD2),
    .G3_TOTAL(G3_TOTAL), .G3_ACTIVE(G3_ACTIVE), .G3_LINES(G3_LINES),
    .G3_VBLANK(G3_VBLANK), .SD_CE_DIV(SD_CE_DIV), .HW(HW)
  ) u_timing (
    .clk(clk), .rst_n(rst_sync_n), .std_sel(std_sel), .chk_sel(chk_sel),
    .amp_sel(amp_sel), .ce(ce), .run(run), .cfg(cfg), .pos(pos), .barw(barw)
  );

  sdi_tpg_pattern #(.HW(HW)) u_pattern (
    .clk(clk), .rst_n(rst_sync_n), .ce(ce), .run(run), .cfg(cfg),
    .pos(pos), .barw(barw), .px(px)
  );

  sdi_tpg_format #(.SD_CE_DIV(SD_CE_DIV)) u_format (
    .clk(clk), .rst_n(rst_sync_n), .ce(ce), .run(run), .cfg(cfg),
    .pos(pos), .px(px), .dout(vid_data), .dval(vid_valid), .std_out(std_code)
  );

endmodule

// File: tb/sdi_pattern_gen_tb.sv
module sdi_pattern_gen_tb;

  localparam int SDT = 48, SDA = 32, SDL = 10, SDV = 2, SDF = 5;
  localparam int HDT = 40, HDA = 24, HDL = 8,  HDV = 1, HDF = 4;
  localparam int GT  = 40, GA  = 24, GL  = 6,  GV  = 1;
  localparam int DIV = 2;
  localparam int MAXW = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  std_sel = 2'b00;
  logic        chk_sel = 1'b0;
  logic        amp_sel = 1'b0;
  logic [19:0] vid_data;
  logic        vid_valid;
  logic [1:0]  std_code;

  logic [19:0] mem  [MAXW];
  logic [1:0]  stdm [MAXW];
  int          cycm [MAXW];
  int          wcnt = 0;
  int          cyc = 0;
  int          fstart = 0;
  int          nchk = 0;
  int          nfail = 0;

  always #2 clk = ~clk;

  sdi_pattern_gen #(
    .SD_TOTAL(SDT), .SD_ACTIVE(SDA), .SD_LINES(SDL), .SD_VBLANK(SDV), .SD_FIELD2(SDF),
    .HD_TOTAL(HDT), .HD_ACTIVE(HDA), .HD_LINES(HDL), .HD_VBLANK(HDV), .HD_FIELD2(HDF),
    .G3_TOTAL(GT), .G3_ACTIVE(GA), .G3_LINES(GL), .G3_VBLANK(GV), .SD_CE_DIV(DIV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .chk_sel(chk_sel), .amp_sel(amp_sel),
    .vid_data(vid_data), .vid_valid(vid_valid), .std_code(std_code)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && vid_valid && wcnt < MAXW) begin
      mem[wcnt]  = vid_data;
      stdm[wcnt] = std_code;
      cycm[wcnt] = cyc;
      wcnt       = wcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] xyz(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  function automatic logic [19:0] wd(input int tot, input int ln, input int h);
    return mem[fstart + ln * tot + h];
  endfunction

  task automatic wait_words(input int n);
    while (wcnt < n) @(negedge clk);
  endtask

  // R12: scan every non-timing word of the current frame
  task automatic scan_reserved(input int tot, input int act, input int lines, input bit sd);
    int bad = 0;
    logic [19:0] w;
    for (int ln = 0; ln < lines; ln++) begin
      for (int h = 4; h < tot; h++) begin
        if (h >= tot - act - 4 && h < tot - act) continue;
        w = wd(tot, ln, h);
        if (w[9:0] < 10'h004 || w[9:0] > 10'h3FB) bad++;
        if (sd) begin
          if (w[19:10] != 10'h000) bad++;
        end else if (w[19:10] < 10'h004 || w[19:10] > 10'h3FB) bad++;
      end
    end
    chk("R12 reserved codes in frame", 20'(bad), 20'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    std_sel = 2'b01; chk_sel = 1'b0; amp_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", {19'd0, vid_valid}, 20'd0);
    chk("R1 data in reset", vid_data, 20'd0);
    chk("R1 std in reset", {18'd0, std_code}, 20'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", {19'd0, vid_valid}, 20'd0);
  endtask

  task automatic t_hd_full;
    int bad = 0;
    wait_words(fstart + 50);
    std_sel = 2'b11; chk_sel = 1'b0; amp_sel = 1'b0;   // for next frame
    wait_words(fstart + HDT * HDL);
    chk("R3 HD EAV word0", wd(HDT, 0, 0), {10'h3FF, 10'h3FF});
    chk("R3 HD EAV word1", wd(HDT, 0, 1), 20'h0);
    chk("R3 HD EAV word2", wd(HDT, 0, 2), 20'h0);
    chk("R4 HD EAV XYZ line0", wd(HDT, 0, 3), {xyz(0, 1, 1), xyz(0, 1, 1)});
    chk("R4 HD SAV XYZ line1", wd(HDT, 1, 15), {xyz(0, 0, 0), xyz(0, 0, 0)});
    chk("R5 HD field2 EAV", wd(HDT, 4, 3), {xyz(1, 1, 1), xyz(1, 1, 1)});
    chk("R5 HD field2 SAV active", wd(HDT, 5, 15), {xyz(1, 0, 0), xyz(1, 0, 0)});
    chk("R6 HD blank word", wd(HDT, 1, 4), {10'h040, 10'h200});
    chk("R6 HD vblank active area", wd(HDT, 4, 20), {10'h040, 10'h200});
    chk("R7 HD white 100", wd(HDT, 1, 16), {10'd940, 10'd512});
    chk("R7 HD yellow luma 100", {10'd0, wd(HDT, 1, 19) >> 10}, {10'd0, 10'd877});
    chk("R8 HD black with Cr", wd(HDT, 1, 39), {10'd64, 10'd512});
    chk("R8 HD yellow Cr", {10'd0, wd(HDT, 1, 19) & 20'h3FF}, 20'd553);
    chk("R10 HD late line still 100", wd(HDT, 7, 16), {10'd940, 10'd512});
    for (int k = 0; k < HDT * HDL; k++) if (stdm[fstart + k] != 2'b01) bad++;
    chk("R2 R10 HD std over frame", 20'(bad), 20'd0);
    chk("R11 HD word rate", 20'(cycm[fstart + 11] - cycm[fstart + 10]), 20'd1);
    scan_reserved(HDT, HDA, HDL, 1'b0);
    fstart += HDT * HDL;
  endtask

  task automatic t_3g_reduced;
    wait_words(fstart + 50);
    std_sel = 2'b00; chk_sel = 1'b1; amp_sel = 1'b1;   // checkfield overrides amp
    wait_words(fstart + GT * GL);
    chk("R10 3G starts at frame word0", wd(GT, 0, 0), {10'h3FF, 10'h3FF});
    chk("R2 3G std code", {18'd0, stdm[fstart]}, 20'd3);
    chk("R4 3G EAV XYZ line0", wd(GT, 0, 3), {xyz(0, 1, 1), xyz(0, 1, 1)});
    chk("R5 3G progressive line4", wd(GT, 4, 3), {xyz(0, 0, 1), xyz(0, 0, 1)});
    chk("R7 3G white 75", wd(GT, 1, 16), {10'd721, 10'd512});
    chk("R7 3G yellow luma 75", {10'd0, wd(GT, 1, 19) >> 10}, {10'd0, 10'd674});
    chk("R7 3G black", wd(GT, 5, 39), {10'd64, 10'd512});
    chk("R11 3G word rate", 20'(cycm[fstart + 31] - cycm[fstart + 30]), 20'd1);
    scan_reserved(GT, GA, GL, 1'b0);
    fstart += GT * GL;
  endtask

  task automatic t_sd_check;
    wait_words(fstart + 50);
    std_sel = 2'b10; chk_sel = 1'b0; amp_sel = 1'b1;
    wait_words(fstart + SDT * SDL);
    chk("R2 SD std code", {18'd0, stdm[fstart]}, 20'd0);
    chk("R3 SD EAV word0", wd(SDT, 0, 0), 20'h003FF);
    chk("R3 SD EAV word1", wd(SDT, 0, 1), 20'h0);
    chk("R4 SD EAV XYZ line0", wd(SDT, 0, 3), {10'h0, xyz(0, 1, 1)});
    chk("R5 SD field2 SAV active", wd(SDT, 7, 15), {10'h0, xyz(1, 0, 0)});
    chk("R5 SD field2 vblank", wd(SDT, 6, 3), {10'h0, xyz(1, 1, 1)});
    chk("R6 SD blank chroma", wd(SDT, 2, 4), 20'h00200);
    chk("R6 SD blank luma", wd(SDT, 2, 5), 20'h00040);
    chk("R9 R8 SD chk Cb", wd(SDT, 2, 16), 20'h00300);
    chk("R9 R8 SD chk Y", wd(SDT, 2, 17), 20'h00198);
    chk("R9 R8 SD chk Cr", wd(SDT, 2, 18), 20'h00300);
    chk("R9 SD chk first half end", wd(SDT, 4, 47), 20'h00198);
    chk("R9 SD chk second half C", wd(SDT, 7, 16), 20'h00200);
    chk("R9 SD chk second half Y", wd(SDT, 9, 17), 20'h00110);
    chk("R11 SD word rate", 20'(cycm[fstart + 21] - cycm[fstart + 20]), 20'(DIV));
    scan_reserved(SDT, SDA, SDL, 1'b1);
    fstart += SDT * SDL;
  endtask

  task automatic t_hd_alias;
    wait_words(fstart + HDT * HDL);
    chk("R2 select 10 reported as HD", {18'd0, stdm[fstart]}, 20'd1);
    chk("R11 HD after SD rate", 20'(cycm[fstart + 5] - cycm[fstart + 4]), 20'd1);
    chk("R7 alias frame white 100", wd(HDT, 1, 16), {10'd940, 10'd512});
    chk("R3 alias EAV", wd(HDT, 3, 0), {10'h3FF, 10'h3FF});
    fstart += HDT * HDL;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_hd_full();
    t_3g_reduced();
    t_sd_check();
    t_hd_alias();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule